// File: doc/BRIEF.md
# Two-Channel Line Status Change Interrupt Latch

This block watches the modem and line status of two serial channels and raises a status interrupt whenever a watched condition changes level, in either direction. Each channel has six edge sources:

- four signals from the pins: carrier detect, clear to send, sync/hunt and break/abort;
- two internal events: transmit underrun/end-of-message and baud counter zero count.

The four pin signals and the two events all pass through a two-flop synchronizer. An edge on a source is noticed only if two conditions hold: the source's bit is set in that channel's enable mask, and the channel's status-interrupt enable is set. A noticed edge sets the channel's pending flag. The status byte then holds the edge-source values seen at that moment, and keeps them until software issues the reset-status command.

Two bits of the status byte always follow their inputs, with no latching: transmit buffer empty and receive character available. A single summary byte gathers the pending flags of both channels. It holds the receive, transmit and status pending bits of channel A and of channel B. The receive and transmit bits come from logic outside this block. A master enable gates the combined interrupt output.

Channel A is index 0 of every per-channel vector, and channel B is index 1.

Top module: `xstat_irq_latch`

## Requirements
- R1: After reset, both status bytes read 0x00 while all inputs are low. The summary byte reads 0x00, `irq_o` is low, and each mask register reads 0xFA.
- R2: A mask write stores the written byte with bits 2 and 0 forced to zero, and it affects only the addressed channel. The bit positions are: 7 break/abort, 6 transmit underrun, 5 CTS, 4 sync/hunt, 3 DCD and 1 zero count. The stored value appears on `mask_o` from the cycle after the write.
- R3: The status byte is laid out as bit 7 break, bit 6 transmit underrun, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD, bit 2 transmit buffer empty, bit 1 zero count and bit 0 receive available.
- R4: A change on an edge-source input reaches the status byte on the third rising clock edge after the change, and no earlier. Bits 2 and 0 of the status byte follow their inputs in the same cycle.
- R5: A rising edge on an enabled source sets that channel's pending flag, provided the channel's status-interrupt enable is set. The flag sets on the same clock edge that updates the status byte, and it stays set until the reset-status command.
- R6: A falling edge on an enabled source sets the pending flag in exactly the same way as a rising edge.
- R7: An edge on a source whose mask bit is clear never sets the pending flag. Neither does any edge while the channel's status-interrupt enable is low. The status byte still follows that source.
- R8: While a channel's status interrupt is pending, its edge-source status bits (7:3 and 1) hold the values captured when the flag set. Bits 2 and 0 stay live.
- R9: A one-cycle reset-status pulse clears a pending flag on the next clock edge. If a source changed while the status byte was frozen, the flag sets again one clock later and the status byte takes the new value. If nothing changed, the flag stays clear.
- R10: The summary byte places channel A receive/transmit/status pending in bits 5/4/3 and channel B receive/transmit/status pending in bits 2/1/0. Bits 7:6 read as zero.
- R11: `irq_o` is high exactly when the master enable is high and at least one summary bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_i | input | 2 | Break/abort level per channel |
| txund_i | input | 2 | Transmit underrun/EOM level per channel |
| cts_i | input | 2 | Clear-to-send level per channel |
| hunt_i | input | 2 | Sync/hunt level per channel |
| dcd_i | input | 2 | Carrier detect level per channel |
| zcount_i | input | 2 | Baud counter zero-count level per channel |
| txe_i | input | 2 | Transmit buffer empty, live status |
| rxa_i | input | 2 | Receive character available, live status |
| rx_ip_i | input | 2 | Receive interrupt pending from outside logic |
| tx_ip_i | input | 2 | Transmit interrupt pending from outside logic |
| mask_we_i | input | 2 | Mask write strobe per channel |
| mask_wd_i | input | 8 | Mask write data |
| stie_i | input | 2 | Status-interrupt enable per channel |
| mie_i | input | 1 | Master interrupt enable |
| rst_stat_i | input | 2 | Reset-status command pulse per channel |
| stat_o | output | 16 | Status bytes, channel A in 7:0 and channel B in 15:8 |
| mask_o | output | 16 | Mask readback, channel A in 7:0 and channel B in 15:8 |
| pend_o | output | 8 | Pending summary byte |
| irq_o | output | 1 | Gated interrupt output |

## Verification
Rising and falling steps are applied to single sources, so that both edge directions are tried, and the result is sampled both one cycle before and exactly on the expected edge. This shows that the full synchronizer latency is present. The same edges are then applied to a masked source and to a channel whose status enable is low, which separates the mask gating from the enable gating.

A source is toggled while the channel is pending, and the reset command is then pulsed. This distinguishes a frozen byte from a live one, and shows whether a change made during the freeze re-arms the interrupt or is lost.

Finally, the summary and interrupt outputs are driven from a mix of outside pending bits and both channels' status flags, with the master enable toggled. This checks the packing order and the output gating.

// File: rtl/xstat_pkg.sv
package xstat_pkg;
   localparam int STAT_W   = 8;
   localparam int NSRC     = 6;
   // Writable mask bits; bits 2 and 0 are reserved and read as zero.
   localparam logic [STAT_W-1:0] MASK_LEGAL = 8'hFA;

   // Internal source vector order: [5] brk, [4] txund, [3] cts, [2] hunt, [1] dcd, [0] zcount
   function automatic logic [NSRC-1:0] mask_to_src(input logic [STAT_W-1:0] m);
      return {m[7:3], m[1]};
   endfunction

   function automatic logic [STAT_W-1:0] pack_status(input logic [NSRC-1:0] s,
                                                     input logic txe, input logic rxa);
      return {s[5:1], txe, s[0], rxa};
   endfunction
endpackage

// File: rtl/xstat_sync.sv
module xstat_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xstat_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("xstat_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d_i;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/xstat_chan.sv
module xstat_chan
   import xstat_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [STAT_W-1:0] MASK_RST    = 8'hFA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              txe_i,
   input  logic              rxa_i,
   input  logic              stie_i,
   input  logic              rst_cmd_i,
   input  logic              mask_we_i,
   input  logic [STAT_W-1:0] mask_wd_i,
   output logic [STAT_W-1:0] stat_o,
   output logic [STAT_W-1:0] mask_o,
   output logic              pend_o
);
   logic [NSRC-1:0]   src_s;
   logic [NSRC-1:0]   snap_q;
   logic [STAT_W-1:0] mask_q;
   logic              pend_q;
   logic [NSRC-1:0]   diff;
   logic              hit;

   xstat_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_s)
   );

   // The shown value doubles as the previous sample for edge detection,
   // so a change made while frozen is seen once the freeze lifts.
   always_comb begin
      diff = src_s ^ snap_q;
      hit  = stie_i & (|(diff & mask_to_src(mask_q)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         pend_q <= 1'b0;
      end else if (!pend_q) begin
         snap_q <= src_s;
         pend_q <= hit;
      end else if (rst_cmd_i) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= MASK_RST & MASK_LEGAL;
      else if (mask_we_i) mask_q <= mask_wd_i & MASK_LEGAL;
   end

   assign stat_o = pack_status(snap_q, txe_i, rxa_i);
   assign mask_o = mask_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/xstat_irq_latch.sv
module xstat_irq_latch
   import xstat_pkg::*;
#(
   parameter int                NCH         = 2,
   parameter int                SYNC_STAGES = 2,
   parameter logic [STAT_W-1:0] MASK_RST    = 8'hFA
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH-1:0]        brk_i,
   input  logic [NCH-1:0]        txund_i,
   input  logic [NCH-1:0]        cts_i,
   input  logic [NCH-1:0]        hunt_i,
   input  logic [NCH-1:0]        dcd_i,
   input  logic [NCH-1:0]        zcount_i,
   input  logic [NCH-1:0]        txe_i,
   input  logic [NCH-1:0]        rxa_i,
   input  logic [NCH-1:0]        rx_ip_i,
   input  logic [NCH-1:0]        tx_ip_i,
   input  logic [NCH-1:0]        mask_we_i,
   input  logic [STAT_W-1:0]     mask_wd_i,
   input  logic [NCH-1:0]        stie_i,
   input  logic                  mie_i,
   input  logic [NCH-1:0]        rst_stat_i,
   output logic [NCH*STAT_W-1:0] stat_o,
   output logic [NCH*STAT_W-1:0] mask_o,
   output logic [STAT_W-1:0]     pend_o,
   output logic                  irq_o
);
   localparam int FLAGS_PER_CH = 3;

   if (NCH != 2) begin : g_bad_nch
      $error("xstat_irq_latch: the summary byte packs exactly two channels");
   end
   if ((MASK_RST & ~MASK_LEGAL) != '0) begin : g_bad_mask_rst
      $error("xstat_irq_latch: MASK_RST sets reserved bits");
   end

   logic [NCH-1:0] st_pend;
   logic [NCH*FLAGS_PER_CH-1:0] flags;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      xstat_chan #(.SYNC_STAGES(SYNC_STAGES), .MASK_RST(MASK_RST)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_i     ({brk_i[ch], txund_i[ch], cts_i[ch], hunt_i[ch], dcd_i[ch], zcount_i[ch]}),
         .txe_i     (txe_i[ch]),
         .rxa_i     (rxa_i[ch]),
         .stie_i    (stie_i[ch]),
         .rst_cmd_i (rst_stat_i[ch]),
         .mask_we_i (mask_we_i[ch]),
         .mask_wd_i (mask_wd_i),
         .stat_o    (stat_o[ch*STAT_W +: STAT_W]),
         .mask_o    (mask_o[ch*STAT_W +: STAT_W]),
         .pend_o    (st_pend[ch])
      );
      // Channel 0 (A) lands in the upper triple, channel 1 (B) in the lower.
      assign flags[(NCH-1-ch)*FLAGS_PER_CH +: FLAGS_PER_CH] = {rx_ip_i[ch], tx_ip_i[ch], st_pend[ch]};
   end

   assign pend_o = {{(STAT_W-NCH*FLAGS_PER_CH){1'b0}}, flags};
   assign irq_o  = mie_i & (|flags);
endmodule

// File: rtl/xstat_irq_latch_chk.sv
module xstat_irq_latch_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mie_i,
   input logic [1:0]  stie_i,
   input logic [1:0]  rst_stat_i,
   input logic [15:0] stat_o,
   input logic [7:0]  pend_o,
   input logic        irq_o
);
   assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mie_i |-> !irq_o);

   assert_clear_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_stat_i[0] && pend_o[3]) |=> !pend_o[3]);

   assert_clear_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_stat_i[1] && pend_o[0]) |=> !pend_o[0]);

   assert_hold_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[3] && !rst_stat_i[0]) |=> pend_o[3]);

   assert_freeze_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[3] |=> ($stable(stat_o[7:3]) && $stable(stat_o[1])));

   assert_freeze_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[0] |=> ($stable(stat_o[15:11]) && $stable(stat_o[9])));

   assert_no_stie_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_o[3] && !stie_i[0]) |=> !pend_o[3]);

   assert_top_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[7:6] == 2'b00);
endmodule

bind xstat_irq_latch xstat_irq_latch_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mie_i      (mie_i),
   .stie_i     (stie_i),
   .rst_stat_i (rst_stat_i),
   .stat_o     (stat_o),
   .pend_o     (pend_o),
   .irq_o      (irq_o)
);

// File: tb/test_xstat_irq_latch.sv
module test_xstat_irq_latch;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  brk = '0, txu = '0, cts = '0, hunt = '0, dcd = '0, zc = '0;
   logic [1:0]  txe = '0, rxa = '0, rxip = '0, txip = '0;
   logic [1:0]  mwe = '0, stie = '0, rcmd = '0;
   logic [7:0]  mwd = '0;
   logic        mie = 1'b0;
   logic [15:0] stat, mask;
   logic [7:0]  pend;
   logic        irq;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   typedef struct {
      string       req;
      int          sel;
      logic [15:0] exp;
   } item_t;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   xstat_irq_latch i_xstat_irq_latch (
      .clk(clk), .rst_n(rst_n),
      .brk_i(brk), .txund_i(txu), .cts_i(cts), .hunt_i(hunt), .dcd_i(dcd), .zcount_i(zc),
      .txe_i(txe), .rxa_i(rxa), .rx_ip_i(rxip), .tx_ip_i(txip),
      .mask_we_i(mwe), .mask_wd_i(mwd), .stie_i(stie), .mie_i(mie), .rst_stat_i(rcmd),
      .stat_o(stat), .mask_o(mask), .pend_o(pend), .irq_o(irq)
   );

   function automatic logic [15:0] actual(int sel);
      case (sel)
         0: return {8'h00, stat[7:0]};
         1: return {8'h00, stat[15:8]};
         2: return {8'h00, pend};
         3: return {15'h0, irq};
         4: return {8'h00, mask[7:0]};
         default: return {8'h00, mask[15:8]};
      endcase
   endfunction

   // Monitor: compare queued expectations shortly after each falling edge.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (actual(it.sel) !== it.exp) begin
               n_bad++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, actual(it.sel), it.exp);
            end
         end
      end
   end

   task automatic push(string req, int sel, logic [15:0] exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic settle();
      wait (q.size() == 0);
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wr_mask(int ch, logic [7:0] v);
      mwd = v;
      mwe[ch] = 1'b1;
      @(posedge clk);
      #1 mwe = '0;
   endtask

   task automatic pulse_rst(int ch);
      rcmd[ch] = 1'b1;
      @(posedge clk);
      #1 rcmd = '0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (400) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         summary();
      end
   end

   initial begin
      tick(3);
      @(negedge clk) rst_n = 1'b1;
      tick(1);
      // R1: reset state
      push("R1 status A", 0, 16'h00); push("R1 status B", 1, 16'h00);
      push("R1 pend", 2, 16'h00); push("R1 irq", 3, 16'h0);
      push("R1 mask A", 4, 16'hFA); push("R1 mask B", 5, 16'hFA);
      settle();

      // R2: mask write with reserved bits forced low, per channel
      wr_mask(0, 8'hFF);
      wr_mask(1, 8'h25);
      tick(1);
      push("R2 mask A", 4, 16'hFA); push("R2 mask B", 5, 16'h20);
      settle();

      // R4/R3: live bits follow in the same cycle
      txe[0] = 1'b1; rxa[0] = 1'b1; mie = 1'b1;
      push("R4 live bits A", 0, 16'h05);
      settle();

      // R7: stie low, CTS edge updates status but does not pend
      cts[0] = 1'b1;
      tick(3);
      push("R7 status A follows", 0, 16'h25); push("R7 no pend stie=0", 2, 16'h00);
      settle();

      // R4/R5: rising DCD, enabled
      stie = 2'b11;
      dcd[0] = 1'b1;
      tick(2);
      push("R4 not yet status", 0, 16'h25); push("R4 not yet pend", 2, 16'h00);
      settle();
      tick(1);
      push("R5 status", 0, 16'h2D); push("R5 pend", 2, 16'h08); push("R11 irq", 3, 16'h1);
      settle();

      // R8: frozen edge bits, live bits still move
      cts[0] = 1'b0; txe[0] = 1'b0;
      tick(3);
      push("R8 frozen status", 0, 16'h29); push("R5 pend held", 2, 16'h08);
      settle();

      // R9: reset-status with change during freeze re-arms
      pulse_rst(0);
      push("R9 cleared", 2, 16'h00); push("R9 still shown", 0, 16'h29);
      settle();
      tick(1);
      push("R9 re-armed", 2, 16'h08); push("R9 new status", 0, 16'h09);
      settle();
      pulse_rst(0);
      tick(2);
      push("R9 stays clear", 2, 16'h00); push("R9 live status", 0, 16'h09);
      settle();

      // R6: falling edge
      dcd[0] = 1'b0;
      tick(3);
      push("R6 falling pend", 2, 16'h08); push("R6 status", 0, 16'h01);
      settle();
      pulse_rst(0);

      // R7: masked source on channel B (mask 0x20: CTS only)
      dcd[1] = 1'b1;
      tick(3);
      push("R7 masked status B", 1, 16'h08); push("R7 masked no pend", 2, 16'h00);
      settle();
      cts[1] = 1'b1;
      tick(3);
      push("R7 enabled CTS B pend", 2, 16'h01); push("R3 status B", 1, 16'h28);
      settle();

      // R10/R11: summary packing and master gating
      rxip = 2'b11; txip = 2'b01;
      push("R10 summary", 2, 16'h35); push("R11 irq on", 3, 16'h1);
      settle();
      mie = 1'b0;
      push("R11 irq gated", 3, 16'h0); push("R10 summary kept", 2, 16'h35);
      settle();
      rxip = '0; txip = '0; mie = 1'b1;
      pulse_rst(1);
      push("R11 irq idle", 3, 16'h0); push("R10 summary clear", 2, 16'h00);
      settle();

      // R3: upper bits and zero count on channel A
      brk[0] = 1'b1; txu[0] = 1'b1; hunt[0] = 1'b1; zc[0] = 1'b1;
      tick(3);
      push("R3 status A full", 0, 16'hD3); push("R5 pend multi", 2, 16'h08);
      settle();

      done = 1;
      summary();
   end
endmodule